// File: doc/BRIEF.md
# Framed Serial Shift Front End

This block is the receive side of a serial link that programs a digitally set resistor. A host lowers an active-low frame select, clocks bits in on the falling edges of a serial clock, and raises the frame select to finish. Received bits enter a 16-bit shift register, most significant bit first. Bits leaving the top of the register are driven out on an open-drain serial output, so the next device in a chain can take its own word from them.

When the frame select rises, the block checks the number of falling clock edges in the frame. If the count is a non-zero multiple of 16, the last 16 bits received become a command word. That word is handed across to the system clock as a one-cycle strobe. Any other count discards the frame. A 16-bit response word from the command decoder forms the first 16 bits shifted out in each frame. A plain no-op frame therefore reads back the result of the previous command.

The serial clock idles high and runs only inside a frame. The block changes the outgoing bit after each rising clock edge, so the next device samples a settled value on the falling edge.

Top module: `spi_frame_rx`

## Requirements
- R1: After reset, `cmd_valid` is 0, `cmd_word` is 0 and `sdo_low` is 0.
- R2: A frame of exactly 16 falling `sclk` edges commits its bits to `cmd_word`, with the first bit sent in bit 15. `cmd_valid` is high for exactly one `clk` cycle, within 8 `clk` cycles after `frame_n` rises.
- R3: A frame that ends before its 16th falling edge, including a frame with no edges, gives no `cmd_valid` pulse and leaves `cmd_word` unchanged.
- R4: A frame of 32 falling edges is accepted, and `cmd_word` holds the last 16 bits received.
- R5: A frame whose edge count is not a multiple of 16 (17, 31 or 33) is rejected. There is no pulse and `cmd_word` is unchanged.
- R6: In a frame, the serial output bit presented before falling edge k (k = 1 to 16) is `resp_word[16-k]`. `resp_word` is held stable during the frame.
- R7: From falling edge 17 onward, the serial output bit presented before edge k is the `din` bit captured at edge k-16.
- R8: The serial output never changes at a falling `sclk` edge. The value just after a falling edge equals the value just before it.
- R9: `sdo_low` is asserted only while `frame_n` is low and the outgoing bit is 0. While `frame_n` is high the output is released.
- R10: The edge counter restarts with every frame. A 16-bit frame that follows an aborted frame commits correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the command handoff |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock; idles high, data is captured on its falling edge |
| frame_n | input | 1 | Active-low frame select; its rising edge ends the frame |
| din | input | 1 | Serial data in, most significant bit first |
| resp_word | input | 16 | Response word from the decoder, shifted out at the start of the next frame |
| sdo_low | output | 1 | Open-drain serial output: 1 pulls the line low, 0 releases it |
| cmd_valid | output | 1 | One-cycle strobe in the `clk` domain marking a new command word |
| cmd_word | output | 16 | Last accepted command word |

## Verification
The embedded assertions check four things on every system clock cycle. The command strobe never lasts two cycles. The command word changes only together with its strobe. The word handed over matches the word captured at the frame edge. The edge counter is clear whenever a frame begins. Directed scenarios cover the rest. These include accepting or rejecting frames by edge count, bit ordering of the committed word, the response word and daisy-chained bits appearing on the serial output, the output holding still across falling edges, and the release of the open-drain output between frames.

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
  parameter int WORD = 16  // power of two: the edge counter wraps at WORD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk,
  input  logic            frame_n,
  input  logic            din,
  input  logic [WORD-1:0] resp_word,
  output logic            sdo_low,
  output logic            cmd_valid,
  output logic [WORD-1:0] cmd_word
);
  localparam int CW = $clog2(WORD);

  logic [WORD-1:0] sr, hold;
  logic [CW-1:0]   cnt;
  logic            full, started, out_q, tog;
  logic [2:0]      sync;
  logic            fresh, accept, sdo_bit, edge_seen;

  assign fresh  = (cnt == '0) && !full;
  assign accept = full && (cnt == '0);

  // first falling edge of a frame takes the response word in parallel
  always_ff @(negedge sclk)
    sr <= {fresh ? resp_word[WORD-2:0] : sr[WORD-2:0], din};

  always_ff @(negedge sclk or posedge frame_n or negedge rst_n)
    if (!rst_n) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (frame_n) begin
      cnt  <= '0;
      full <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(WORD-1)) full <= 1'b1;
    end

  always_ff @(posedge sclk or posedge frame_n or negedge rst_n)
    if (!rst_n)       started <= 1'b0;
    else if (frame_n) started <= 1'b0;
    else              started <= 1'b1;

  always_ff @(posedge sclk) out_q <= sr[WORD-1];

  assign sdo_bit = started ? out_q : resp_word[WORD-1];
  assign sdo_low = !frame_n && !sdo_bit;

  always_ff @(posedge frame_n) if (accept) hold <= sr;

  always_ff @(posedge frame_n or negedge rst_n)
    if (!rst_n)      tog <= 1'b0;
    else if (accept) tog <= ~tog;

  assign edge_seen = sync[2] ^ sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync      <= '0;
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
    end else begin
      sync      <= {sync[1:0], tog};
      cmd_valid <= edge_seen;
      if (edge_seen) cmd_word <= hold;
    end

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd_word));

  assert_word_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_word == hold));

  assert_counter_fresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> (cnt == '0 && !full));
endmodule

// File: tb/spi_frame_rx_test.sv
`timescale 1ns/1ps
module spi_frame_rx_test;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, frame_n = 1'b1, din = 1'b0;
  logic [15:0] resp_word = '0;
  logic sdo_low, cmd_valid;
  logic [15:0] cmd_word;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;
  logic [63:0] seen, seen_after;

  spi_frame_rx uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .frame_n(frame_n), .din(din),
    .resp_word(resp_word), .sdo_low(sdo_low), .cmd_valid(cmd_valid), .cmd_word(cmd_word));

  always #2.5 clk = ~clk;

  always @(negedge clk) if (rst_n && cmd_valid) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drives n bits of data (highest first); records the line before and after each falling edge
  task automatic run_frame(input int n, input logic [63:0] data, output int strobes);
    int p0 = pulses;
    frame_n = 1'b0; #10;
    for (int i = 0; i < n; i++) begin
      din = data[n-1-i]; #10;
      seen[i] = ~sdo_low;
      sclk = 1'b0; #5;
      seen_after[i] = ~sdo_low; #15;
      sclk = 1'b1; #10;
    end
    #10; frame_n = 1'b1; din = 1'b0;
    #40; strobes = pulses - p0;
    #60;
  endtask

  function automatic logic [15:0] out_word(input int first);
    logic [15:0] w;
    for (int k = 0; k < 16; k++) w[15-k] = seen[first+k];
    return w;
  endfunction

  task automatic test_reset();
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 cmd_word", cmd_word, 0);
    check("R1 sdo_low", sdo_low, 0);
  endtask

  task automatic test_single_word();
    int s;
    resp_word = 16'hA5C3;
    run_frame(16, 64'h1B7E, s);
    check("R2 strobe count", s, 1);
    check("R2 word", cmd_word, 16'h1B7E);
    check("R6 response out", out_word(0), 16'hA5C3);
    check("R8 no change at fall", seen_after[15:0], seen[15:0]);
  endtask

  task automatic test_abort();
    int s;
    run_frame(9, 64'h1FF, s);
    check("R3 short frame strobe", s, 0);
    check("R3 short frame word", cmd_word, 16'h1B7E);
    run_frame(0, 64'h0, s);
    check("R3 empty frame strobe", s, 0);
    check("R3 empty frame word", cmd_word, 16'h1B7E);
  endtask

  task automatic test_chain32();
    int s;
    resp_word = 16'h3C96;
    run_frame(32, 64'hDEAD_0F0F, s);
    check("R4 strobe count", s, 1);
    check("R4 word", cmd_word, 16'h0F0F);
    check("R6 response out", out_word(0), 16'h3C96);
    check("R7 pass-through", out_word(16), 16'hDEAD);
    check("R8 no change at fall", seen_after[31:0], seen[31:0]);
  endtask

  task automatic test_bad_counts();
    int s;
    run_frame(17, 64'h1_2345, s);
    check("R5 17 edges strobe", s, 0);
    run_frame(31, 64'h7654_3210, s);
    check("R5 31 edges strobe", s, 0);
    run_frame(33, 64'h1_CAFE_BABE, s);
    check("R5 33 edges strobe", s, 0);
    check("R5 word unchanged", cmd_word, 16'h0F0F);
  endtask

  task automatic test_recover();
    int s;
    run_frame(5, 64'h15, s);
    check("R10 abort strobe", s, 0);
    run_frame(16, 64'h8001, s);
    check("R10 strobe after abort", s, 1);
    check("R10 word after abort", cmd_word, 16'h8001);
  endtask

  task automatic test_release();
    resp_word = 16'h0000; #20;
    check("R9 idle released", sdo_low, 0);
    frame_n = 1'b0; #10;
    check("R9 driven low in frame", sdo_low, 1);
    frame_n = 1'b1; #10;
    check("R9 released after frame", sdo_low, 0);
    #100;
  endtask

  initial begin
    #22 rst_n = 1'b1;
    #20;
    test_reset();
    test_single_word();
    test_abort();
    test_chain32();
    test_bad_counts();
    test_recover();
    test_release();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule